// File: doc/BRIEF.md
# Charge-Transfer Capacitive Touch Acquisition Controller

The block measures a group of capacitive touch electrodes by charge transfer. A centre-aligned up/down phase counter produces two phase signals, one that charges the electrode and one that transfers that charge onto a sample capacitor. The two phases never overlap. A shared cycle counter counts completed transfer phases. Each enabled channel has a comparator on its sample capacitor. When that comparator reports that the sample voltage has crossed its threshold, the current cycle count is stored as the channel's result. A larger stored count means less electrode capacitance per transfer, so a touch shows up as a drop in the count.

An acquisition starts with a one-cycle start strobe and a channel enable mask. The controller first holds the sample pins of the enabled channels low for a fixed discharge time. It then releases those pins and switches the enabled electrodes to pulse drive. Every enabled channel sits in a pending set until one of two things retires it: its own comparator crossing, or the cycle counter reaching its overflow limit. When the pending set is empty, the phases stop, every sample and electrode pin is parked low, and the done flag rises. A start strobe with an empty mask raises done at once and produces no pulses.

The comparator inputs are asynchronous. They pass through a two-stage synchronizer and are sampled once per period, one clock into the charge phase that follows each transfer. Each crossing is therefore credited to the transfer that caused it.

Top module: `ct_touch_acq`

## Requirements
- R1: After reset, `done` is 0, all bits of `sampleDrvLow` and `elecDrvLow` are 1, `elecPulseEn` and `cmpRoute` are 0, both phase outputs are 0 and every result field is 0.
- R2: A start strobe while idle with `chanEn` equal to zero sets `done` on the next clock edge. It produces no phase activity and leaves every result unchanged.
- R3: A start strobe while idle with a non-zero mask clears `done` and begins a discharge window of `DIS_CYCLES` clocks. In that window `sampleDrvLow` equals the mask and `elecDrvLow` is 0. Afterwards `sampleDrvLow` is 0 and `elecPulseEn` equals the mask.
- R4: During acquisition `chargePh` and `xferPh` are never high together. In steady state the period is 2*RELOAD clocks: `chargePh` is high for RELOAD-1 clocks and `xferPh` for RELOAD-3 clocks.
- R5: If a channel's comparator input goes high after the K-th falling edge of `xferPh` (K <= ACQ_MAX), that channel's result is K. Result field i occupies bits [i*CNT_W +: CNT_W] of `results`.
- R6: A pending channel whose comparator has not crossed by the (ACQ_MAX+1)-th completed transfer receives the result ACQ_MAX+1.
- R7: `done` rises only after every enabled channel has been retired. At that point both phases stop and every bit of `sampleDrvLow` and `elecDrvLow` returns to 1.
- R8: A channel outside the mask never has `elecPulseEn` set, and its result keeps its previous value whatever its comparator input does.
- R9: `cmpRoute` bit i is 1 while channel i is pending and drops when it retires. After that, the comparator level has no effect on the channel's result.
- R10: A start strobe during discharge or acquisition is ignored, including its mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| startReq | input | 1 | One-cycle request to start an acquisition |
| chanEn | input | NUM_CH | Channel enable mask, sampled with `startReq` |
| cmpIn | input | NUM_CH | Asynchronous sample-level comparator outputs |
| sampleDrvLow | output | NUM_CH | 1 drives the sample pin low, 0 releases it to input |
| elecDrvLow | output | NUM_CH | 1 drives the electrode pin low |
| elecPulseEn | output | NUM_CH | 1 routes the phase pulses onto the electrode |
| cmpRoute | output | NUM_CH | Comparator routing, active while the channel is pending |
| chargePh | output | 1 | Charge phase |
| xferPh | output | 1 | Transfer phase |
| results | output | NUM_CH*CNT_W | Captured counts, one field per channel |
| done | output | 1 | Acquisition complete, held until the next accepted start |

## Verification
The assertions assume that `startReq` is asserted only to request a run and that `chanEn` is stable in the cycle the strobe is sampled. They make no assumption about the comparator timing. The stimulus drives every input on the falling clock edge and holds the start strobe for exactly one clock. Comparator inputs are raised only just after a falling edge of `xferPh`, which gives the synchronizer its two clocks before the next sampling point. All comparator inputs are returned low between runs, so no stale level crosses into the next discharge window.

// File: rtl/ct_touch_pkg.sv
package ct_touch_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_DISCH = 2'd1,
    ST_ACQ   = 2'd2
  } ctState_e;

  // Strobes from the sequencer to the datapath.
  typedef struct packed {
    logic loadPend;  // load the pending set and clear the cycle counter
    logic runPh;     // let the phase counter run
  } ctStrobe_t;

endpackage

// File: rtl/ctPhaseGen.sv
// Centre-aligned up/down phase counter producing non-overlapping charge and
// transfer phases plus a once-per-period sampling tick.
module ctPhaseGen #(
  parameter int RELOAD = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic chargePh,
  output logic xferPh,
  output logic cycTick
);
  localparam int HALF = RELOAD / 2;
  localparam int PH_W = $clog2(RELOAD + 1);
  localparam logic [PH_W-1:0] TOP_V    = PH_W'(RELOAD);
  localparam logic [PH_W-1:0] NEAR_TOP = PH_W'(RELOAD - 1);
  localparam logic [PH_W-1:0] CHG_CMP  = PH_W'(HALF + 1);
  localparam logic [PH_W-1:0] XFR_CMP  = PH_W'(HALF - 1);
  localparam logic [PH_W-1:0] ONE_V    = PH_W'(1);

  logic [PH_W-1:0] phCnt;
  logic            dirUp;

  // Parked at the top counting down, so a run opens inside a charge phase.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phCnt <= TOP_V;
      dirUp <= 1'b0;
    end else if (!run) begin
      phCnt <= TOP_V;
      dirUp <= 1'b0;
    end else if (dirUp) begin
      phCnt <= phCnt + ONE_V;
      if (phCnt == NEAR_TOP) dirUp <= 1'b0;
    end else begin
      phCnt <= phCnt - ONE_V;
      if (phCnt == ONE_V) dirUp <= 1'b1;
    end
  end

  // Charge around the top, transfer around the bottom, a dead gap on both
  // sides of mid-range.
  assign chargePh = run && (phCnt >= CHG_CMP);
  assign xferPh   = run && (phCnt <  XFR_CMP);
  // First clock of charge on the way up: two clocks after transfer ends.
  assign cycTick  = run && dirUp && (phCnt == CHG_CMP);

  a_r4_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(chargePh && xferPh));

  a_r4_tick_in_charge: assert property (@(posedge clk) disable iff (!rst_n)
    cycTick |=> chargePh);

endmodule

// File: rtl/ctCmpSync.sv
// Two-stage synchronizer for the asynchronous comparator levels.
module ctCmpSync #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= '0;
      dout   <= '0;
    end else begin
      stage1 <= din;
      dout   <= stage1;
    end
  end
endmodule

// File: rtl/ctTouchDatapath.sv
// Shared cycle counter, pending set and per-channel capture registers.
module ctTouchDatapath
  import ct_touch_pkg::*;
#(
  parameter int NUM_CH  = 4,
  parameter int CNT_W   = 16,
  parameter int RELOAD  = 8,
  parameter int ACQ_MAX = 20
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  ctStrobe_t               str,
  input  logic [NUM_CH-1:0]       chanEn,
  input  logic [NUM_CH-1:0]       cmpIn,
  output logic                    chargePh,
  output logic                    xferPh,
  output logic [NUM_CH-1:0]       cmpRoute,
  output logic [NUM_CH*CNT_W-1:0] results,
  output logic                    pendEmpty
);
  localparam logic [CNT_W-1:0] OVF_VAL = CNT_W'(ACQ_MAX + 1);
  localparam logic [CNT_W-1:0] MIN_VAL = CNT_W'(1);

  logic              cycTick;
  logic [NUM_CH-1:0] cmpSync;
  logic [NUM_CH-1:0] pending;
  logic [NUM_CH-1:0] retire;
  logic [CNT_W-1:0]  cycCnt;
  logic [CNT_W-1:0]  nextCnt;
  logic              overflow;

  ctPhaseGen #(.RELOAD(RELOAD)) u_phase (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (str.runPh),
    .chargePh (chargePh),
    .xferPh   (xferPh),
    .cycTick  (cycTick)
  );

  ctCmpSync #(.W(NUM_CH)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (cmpIn),
    .dout  (cmpSync)
  );

  assign nextCnt  = cycCnt + MIN_VAL;
  assign overflow = cycTick && (nextCnt == OVF_VAL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cycCnt <= '0;
    else if (str.loadPend) cycCnt <= '0;
    else if (cycTick)      cycCnt <= nextCnt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            pending <= '0;
    else if (str.loadPend) pending <= chanEn;
    else                   pending <= pending & ~retire;
  end

  generate
    for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
      logic [CNT_W-1:0] resReg;

      // A crossing and an overflow on the same tick store the same value.
      assign retire[g] = pending[g] && cycTick && (cmpSync[g] || overflow);

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         resReg <= '0;
        else if (retire[g]) resReg <= nextCnt;
      end

      assign results[g*CNT_W +: CNT_W] = resReg;

      a_r6_result_range: assert property (@(posedge clk) disable iff (!rst_n)
        retire[g] |=> (resReg >= MIN_VAL) && (resReg <= OVF_VAL));

      a_r9_route_drops: assert property (@(posedge clk) disable iff (!rst_n)
        retire[g] |=> !cmpRoute[g]);
    end
  endgenerate

  assign cmpRoute  = pending;
  assign pendEmpty = ~|pending;

  a_r9_pending_shrinks: assert property (@(posedge clk) disable iff (!rst_n)
    !str.loadPend |=> ((pending & ~$past(pending)) == '0));

  a_r6_overflow_retires_all: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> pendEmpty);

endmodule

// File: rtl/ctTouchCtrl.sv
// Acquisition sequencer: idle, discharge, acquire; owns pin modes and done.
module ctTouchCtrl
  import ct_touch_pkg::*;
#(
  parameter int NUM_CH     = 4,
  parameter int DIS_CYCLES = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              startReq,
  input  logic [NUM_CH-1:0] chanEn,
  input  logic              pendEmpty,
  output ctStrobe_t         str,
  output logic [NUM_CH-1:0] sampleDrvLow,
  output logic [NUM_CH-1:0] elecDrvLow,
  output logic [NUM_CH-1:0] elecPulseEn,
  output logic              done
);
  localparam int DC_W = $clog2(DIS_CYCLES + 1);
  localparam logic [DC_W-1:0] DIS_LAST = DC_W'(DIS_CYCLES - 1);
  localparam logic [DC_W-1:0] DC_ONE   = DC_W'(1);

  ctState_e          state;
  logic [DC_W-1:0]   disCnt;
  logic [NUM_CH-1:0] actMask;
  logic              anyEn;

  assign anyEn = |chanEn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      disCnt  <= '0;
      actMask <= '0;
      done    <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (startReq) begin
            if (anyEn) begin
              state   <= ST_DISCH;
              disCnt  <= '0;
              actMask <= chanEn;
              done    <= 1'b0;
            end else begin
              done    <= 1'b1;
            end
          end
        end
        ST_DISCH: begin
          disCnt <= disCnt + DC_ONE;
          if (disCnt == DIS_LAST) state <= ST_ACQ;
        end
        ST_ACQ: begin
          if (pendEmpty) begin
            state <= ST_IDLE;
            done  <= 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    str.loadPend = (state == ST_IDLE) && startReq && anyEn;
    str.runPh    = (state == ST_ACQ);
    sampleDrvLow = '1;
    elecDrvLow   = '1;
    elecPulseEn  = '0;
    case (state)
      ST_DISCH: begin
        sampleDrvLow = actMask;
        elecDrvLow   = '0;
      end
      ST_ACQ: begin
        sampleDrvLow = '0;
        elecDrvLow   = '0;
        elecPulseEn  = actMask;
      end
      default: ;
    endcase
  end

  a_r2_empty_start_done: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE && startReq && !anyEn) |=> done);

  a_r7_done_only_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> pendEmpty);

  a_r10_mask_held: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_IDLE) |=> $stable(actMask));

endmodule

// File: rtl/ct_touch_acq.sv
// Top: sequencer plus datapath.
module ct_touch_acq
  import ct_touch_pkg::*;
#(
  parameter int NUM_CH     = 4,
  parameter int CNT_W      = 16,
  parameter int RELOAD     = 8,
  parameter int ACQ_MAX    = 20,
  parameter int DIS_CYCLES = 128
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    startReq,
  input  logic [NUM_CH-1:0]       chanEn,
  input  logic [NUM_CH-1:0]       cmpIn,
  output logic [NUM_CH-1:0]       sampleDrvLow,
  output logic [NUM_CH-1:0]       elecDrvLow,
  output logic [NUM_CH-1:0]       elecPulseEn,
  output logic [NUM_CH-1:0]       cmpRoute,
  output logic                    chargePh,
  output logic                    xferPh,
  output logic [NUM_CH*CNT_W-1:0] results,
  output logic                    done
);
  ctStrobe_t str;
  logic      pendEmpty;

  ctTouchCtrl #(
    .NUM_CH     (NUM_CH),
    .DIS_CYCLES (DIS_CYCLES)
  ) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .startReq     (startReq),
    .chanEn       (chanEn),
    .pendEmpty    (pendEmpty),
    .str          (str),
    .sampleDrvLow (sampleDrvLow),
    .elecDrvLow   (elecDrvLow),
    .elecPulseEn  (elecPulseEn),
    .done         (done)
  );

  ctTouchDatapath #(
    .NUM_CH  (NUM_CH),
    .CNT_W   (CNT_W),
    .RELOAD  (RELOAD),
    .ACQ_MAX (ACQ_MAX)
  ) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .str       (str),
    .chanEn    (chanEn),
    .cmpIn     (cmpIn),
    .chargePh  (chargePh),
    .xferPh    (xferPh),
    .cmpRoute  (cmpRoute),
    .results   (results),
    .pendEmpty (pendEmpty)
  );

  a_r7_parked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (|elecDrvLow) |-> !(chargePh || xferPh));

  a_r3_no_pulse_before_release: assert property (@(posedge clk) disable iff (!rst_n)
    (|sampleDrvLow) |-> (elecPulseEn == '0));

endmodule

// File: tb/test_ct_touch_acq.sv
module test_ct_touch_acq;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_CH     = 4;
  localparam int CNT_W      = 16;
  localparam int RELOAD     = 8;
  localparam int ACQ_MAX    = 20;
  localparam int DIS_CYCLES = 128;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic startReq = 1'b0;
  logic [NUM_CH-1:0] chanEn = '0;
  logic [NUM_CH-1:0] cmpIn = '0;
  logic [NUM_CH-1:0] sampleDrvLow, elecDrvLow, elecPulseEn, cmpRoute;
  logic chargePh, xferPh, done;
  logic [NUM_CH*CNT_W-1:0] resFlat;

  int checks = 0;
  int errors = 0;
  int prevRes[NUM_CH];

  always #(CLK_PERIOD/2) clk = ~clk;

  ct_touch_acq #(
    .NUM_CH(NUM_CH), .CNT_W(CNT_W), .RELOAD(RELOAD),
    .ACQ_MAX(ACQ_MAX), .DIS_CYCLES(DIS_CYCLES)
  ) i_ct_touch_acq (
    .clk(clk), .rst_n(rst_n), .startReq(startReq), .chanEn(chanEn),
    .cmpIn(cmpIn), .sampleDrvLow(sampleDrvLow), .elecDrvLow(elecDrvLow),
    .elecPulseEn(elecPulseEn), .cmpRoute(cmpRoute), .chargePh(chargePh),
    .xferPh(xferPh), .results(resFlat), .done(done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int resOf(input int ch);
    return int'(resFlat[ch*CNT_W +: CNT_W]);
  endfunction

  task automatic checkParked(input string req);
    chk(sampleDrvLow == '1, {req, " sample pins parked"}, int'(sampleDrvLow), 15);
    chk(elecDrvLow == '1, {req, " electrode pins parked"}, int'(elecDrvLow), 15);
    chk(elecPulseEn == '0, {req, " no pulse drive"}, int'(elecPulseEn), 0);
    chk(!chargePh && !xferPh, {req, " phases idle"}, int'({chargePh, xferPh}), 0);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(done == 1'b0, "R1 done after reset", int'(done), 0);
    checkParked("R1");
    chk(cmpRoute == '0, "R1 routing off", int'(cmpRoute), 0);
    for (int ch = 0; ch < NUM_CH; ch++) begin
      chk(resOf(ch) == 0, "R1 result cleared", resOf(ch), 0);
      prevRes[ch] = 0;
    end
    rst_n = 1'b1;
    @(negedge clk);
    checkParked("R1 after release");
  endtask

  task automatic t_empty();
    bit sawPh = 1'b0;
    chanEn = '0;
    startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    chk(done == 1'b1, "R2 empty start done", int'(done), 1);
    for (int i = 0; i < 2*RELOAD; i++) begin
      if (chargePh || xferPh) sawPh = 1'b1;
      @(negedge clk);
    end
    chk(!sawPh, "R2 no phases", int'(sawPh), 0);
    checkParked("R2");
    for (int ch = 0; ch < NUM_CH; ch++)
      chk(resOf(ch) == prevRes[ch], "R2 result untouched", resOf(ch), prevRes[ch]);
  endtask

  // k value: transfer count after which the comparator goes high, 0 = never.
  task automatic run_case(input logic [NUM_CH-1:0] en, input int k0, input int k1,
                          input int k2, input int k3, input bit poke);
    int kArr[NUM_CH];
    int expRes[NUM_CH];
    int maxEff = 0;
    int disLen = 0;
    int cyc = 0;
    int fallCnt = 0;
    int lastRise = -1;
    int riseCnt = 0;
    int chargeRun = 0;
    int widthSeen = 0;
    bit prevC = 1'b0, prevX = 1'b0;
    bit overlap = 1'b0, periodOk = 1'b1, widthOk = 1'b1, leak = 1'b0, routeOk = 1'b1;
    kArr = '{k0, k1, k2, k3};
    for (int ch = 0; ch < NUM_CH; ch++) begin
      if (en[ch]) begin
        expRes[ch] = (kArr[ch] == 0 || kArr[ch] > ACQ_MAX) ? ACQ_MAX + 1 : kArr[ch];
        if (expRes[ch] > maxEff) maxEff = expRes[ch];
      end else begin
        expRes[ch] = prevRes[ch];
      end
    end
    chanEn = en;
    cmpIn = '0;
    startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    chk(done == 1'b0, "R3 done cleared", int'(done), 0);
    chk(sampleDrvLow == en, "R3 discharge sample pins", int'(sampleDrvLow), int'(en));
    chk(elecDrvLow == '0, "R3 electrodes released", int'(elecDrvLow), 0);
    while (sampleDrvLow == en && disLen < 1000) begin
      disLen++;
      @(negedge clk);
    end
    chk(disLen == DIS_CYCLES, "R3 discharge length", disLen, DIS_CYCLES);
    chk(sampleDrvLow == '0, "R3 sample released", int'(sampleDrvLow), 0);
    chk(elecPulseEn == en, "R3 electrodes pulsed", int'(elecPulseEn), int'(en));
    while (!done && cyc < 5000) begin
      if (chargePh && xferPh) overlap = 1'b1;
      if ((elecPulseEn & ~en) != '0) leak = 1'b1;
      if (chargePh && !prevC) begin
        riseCnt++;
        if (riseCnt > 2 && cyc - lastRise != 2*RELOAD) periodOk = 1'b0;
        lastRise = cyc;
      end
      if (chargePh) chargeRun++;
      if (!chargePh && prevC) begin
        if (widthSeen > 0 && chargeRun != RELOAD - 1) widthOk = 1'b0;
        widthSeen++;
        chargeRun = 0;
      end
      if (prevX && !xferPh) begin
        fallCnt++;
        for (int ch = 0; ch < NUM_CH; ch++)
          if (kArr[ch] == fallCnt) begin
            if (en[ch] && !cmpRoute[ch]) routeOk = 1'b0;
            cmpIn[ch] = 1'b1;
          end
      end
      if (poke && cyc == 40) begin startReq = 1'b1; chanEn = '0; end
      if (poke && cyc == 41) begin startReq = 1'b0; chanEn = en; end
      prevC = chargePh;
      prevX = xferPh;
      cyc++;
      @(negedge clk);
    end
    chk(cyc < 5000, "R7 run completes", cyc, 5000);
    chk(!overlap, "R4 phases never overlap", int'(overlap), 0);
    chk(periodOk && riseCnt > 2, "R4 period of 2*RELOAD", riseCnt, 3);
    chk(widthOk && widthSeen > 1, "R4 charge width RELOAD-1", widthSeen, 2);
    chk(!leak, "R8 disabled electrode not pulsed", int'(leak), 0);
    chk(routeOk, "R9 routing on while pending", int'(routeOk), 1);
    chk(fallCnt == maxEff, "R7 done after last retire", fallCnt, maxEff);
    if (poke) chk(cyc > 42, "R10 start while busy ignored", cyc, 43);
    checkParked("R7");
    chk(cmpRoute == '0, "R9 routing cleared", int'(cmpRoute), 0);
    for (int ch = 0; ch < NUM_CH; ch++) begin
      if (!en[ch])
        chk(resOf(ch) == expRes[ch], "R8 disabled result kept", resOf(ch), expRes[ch]);
      else if (expRes[ch] > ACQ_MAX)
        chk(resOf(ch) == expRes[ch], "R6 overflow result", resOf(ch), expRes[ch]);
      else
        chk(resOf(ch) == expRes[ch], "R5 R9 captured count", resOf(ch), expRes[ch]);
      prevRes[ch] = expRes[ch];
    end
    cmpIn = '0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_empty();
    run_case(4'b1111, 2, 5, 3, 7, 1'b0);
    run_case(4'b0101, 4, 2, 1, 3, 1'b0);
    run_case(4'b1011, 0, 20, 9, 0, 1'b0);
    run_case(4'b1111, 2, 4, 6, 9, 1'b1);
    t_empty();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule